// File: doc/BRIEF.md
# Edge-Configurable Pulse Accumulator

This block counts activity on one external input pin and presents the result through a small register port. Software programs a control register, reads or presets a counter register, and services a flag register. Each flag is cleared by writing a one to its bit.

In event mode, every selected transition of the synchronized pin adds one to the counter. In gated mode, the counter advances on a selectable time base for as long as the pin sits at its active level. The transition that ends the active period sets the edge flag.

A single polarity bit has a different meaning in each mode:
- In event mode it chooses rising or falling edges.
- In gated mode it chooses the active level, and with it the trailing edge.

The time base can come from four sources:
- a prescaler strobe supplied from outside,
- every clock,
- one of two internal power-of-two dividers, which restart whenever the block is disabled.

There are two interrupt outputs, one for the edge flag and one for counter overflow. Each is gated by its own enable bit.

Top module: `pulse_accum`

## Requirements
- R1: After reset the control, flag and count registers read 0, and both interrupt outputs are low.
- R2: While the enable bit (control bit 6) is 0, pin activity changes neither the counter nor any flag. A software write to the count register still loads it.
- R3: In event mode (control bit 5 = 0), the counter adds one per falling pin edge when the polarity bit (control bit 4) is 0, and one per rising pin edge when it is 1. No other edge is counted.
- R4: In gated mode (control bit 5 = 1), the counter adds one per time-base tick. It does so only while the synchronized pin is high (polarity 0) or low (polarity 1). At the inactive level, ticks have no effect.
- R5: The edge flag (flag register bit 0) is set by the falling pin edge when polarity is 0 and by the rising edge when polarity is 1, in both modes. In gated mode the leading edge of an active period does not set it.
- R6: Rate select (control bits 3:2) picks the gated time base:
  - 0: the external strobe `presc_tick`,
  - 1: every clock,
  - 2: one tick per 2^DIV_A_LOG2 enabled cycles,
  - 3: one tick per 2^DIV_B_LOG2 enabled cycles.
  For rates 2 and 3 the cycles are counted from the write that enables the block.
- R7: An increment from all-ones wraps the counter to 0 and sets the overflow flag (flag register bit 1).
- R8: Writing a 1 to a flag bit clears that flag. Writing a 0 leaves it unchanged.
- R9: `irq_edge` is high while the edge flag and the edge interrupt enable (control bit 0) are both 1. `irq_ovf` is high while the overflow flag and the overflow interrupt enable (control bit 1) are both 1.
- R10: A write to the count register (address 2) loads the written value. It takes priority over an increment in the same cycle.
- R11: Control register bit 7 is not stored and reads 0. Bits 6:0 read back as written. Address 0 is the control register and address 1 is the flag register.
- R12: The pin passes through a SYNC_STAGES-flop synchronizer. Each pin transition is detected once, and the counter never changes by more than one per cycle except through a software load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select (0 control, 1 flags, 2 count) |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data for `addr`, combinational |
| pin_in | input | 1 | Asynchronous accumulator input |
| presc_tick | input | 1 | One-cycle strobe from the external prescaler |
| irq_edge | output | 1 | Edge flag interrupt |
| irq_ovf | output | 1 | Overflow flag interrupt |

## Verification
The assertions take the following for granted:
- A count-register write is the only path by which the counter may jump.
- `presc_tick` is a single-cycle strobe.
- Pin transitions are spaced at least one clock apart, so the synchronizer never merges two edges.

The stimulus drives all inputs on the falling clock edge. It holds each pin level for two or more cycles, changes the pin only while the block is disabled or in the intended mode, and issues prescaler strobes one cycle wide with idle cycles between them. The divider checks close their windows half a divider period away from any tick, so the expected count does not depend on exact phase.

// File: rtl/pulse_accum_pkg.sv
// Package: shared register addresses and the control register layout.
// Assumes the register port is two address bits wide.
package pulse_accum_pkg;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_FLAG  = 2'd1;
    localparam logic [1:0] ADDR_COUNT = 2'd2;

    localparam int FLAG_EDGE_BIT = 0;
    localparam int FLAG_OVF_BIT  = 1;

    typedef enum logic [1:0] {
        RATE_EXT   = 2'd0,
        RATE_CLK   = 2'd1,
        RATE_DIV_A = 2'd2,
        RATE_DIV_B = 2'd3
    } rate_e;

    // Bits 6..0 of the control register, MSB first.
    typedef struct packed {
        logic  en;
        logic  gated;
        logic  pol;
        rate_e rate;
        logic  ovf_ie;
        logic  edge_ie;
    } ctrl_t;

endpackage

// File: rtl/pulse_accum_pin.sv
// Pin conditioner: synchronizes the asynchronous input through a flop chain
// and reports the stable level plus one-cycle rise and fall pulses.
// Assumes the input holds each level for at least one clock period.
module pulse_accum_pin #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    // Shift the raw pin through the synchronizer chain.
    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= pin_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[SYNC_STAGES-2:0], pin_in};
            end
        end
    endgenerate

    // Keep the previous synchronized sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[SYNC_STAGES-1];
    end

    // Derive level and single-cycle edge pulses.
    always_comb begin
        level = chain_q[SYNC_STAGES-1];
        rise  = level & ~prev_q;
        fall  = ~level & prev_q;
    end
endmodule

// File: rtl/pulse_accum_rate.sv
// Time-base selector: picks the external strobe, every clock, or one of two
// power-of-two divisions of the clock. The divider is held at zero while
// run is low, so its phase starts at the enabling write.
// Assumes DIV_A_LOG2 < DIV_B_LOG2 and DIV_A_LOG2 >= 1.
module pulse_accum_rate
    import pulse_accum_pkg::*;
#(
    parameter int DIV_A_LOG2 = 8,
    parameter int DIV_B_LOG2 = 16
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run,
    input  rate_e sel,
    input  logic  ext_tick,
    output logic  tick
);
    logic [DIV_B_LOG2-1:0] div_q;
    logic                  tick_a;
    logic                  tick_b;

    // Free-running divider, cleared whenever the block is idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) div_q <= '0;
        else                div_q <= div_q + 1'b1;
    end

    // Terminal counts of the short and long divisions.
    always_comb begin
        tick_a = &div_q[DIV_A_LOG2-1:0];
        tick_b = &div_q;
    end

    // Route the selected source to the output.
    always_comb begin
        unique case (sel)
            RATE_EXT:   tick = ext_tick;
            RATE_CLK:   tick = 1'b1;
            RATE_DIV_A: tick = tick_a;
            RATE_DIV_B: tick = tick_b;
            default:    tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/pulse_accum_core.sv
// Counter core: a CNT_W-bit accumulator with software load and wrap report.
// A load in the same cycle as a step wins; wrap pulses only on a real
// all-ones to zero increment.
module pulse_accum_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wrap
);
    // Flag the increment that rolls the counter over.
    always_comb begin
        wrap = step & ~load & (&cnt_q);
    end

    // Update the accumulator: load first, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (step) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pulse_accum.sv
// Pulse accumulator top: register port, mode logic and flags.
// Event mode counts the polarity-selected pin edge; gated mode counts the
// selected time base while the pin is at its active level. The edge that
// sets the edge flag is the same in both modes. Assumes single-cycle writes.
module pulse_accum
    import pulse_accum_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_A_LOG2  = 8,
    parameter int DIV_B_LOG2  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              pin_in,
    input  logic              presc_tick,
    output logic              irq_edge,
    output logic              irq_ovf
);
    localparam int CTRL_W = $bits(ctrl_t);

    ctrl_t            ctrl_q;
    logic             edge_flag_q;
    logic             ovf_flag_q;
    logic             level, rise, fall;
    logic             rate_tick;
    logic             edge_hit, gate_on, step, edge_set;
    logic             wr_ctrl, wr_flag, wr_count;
    logic [CNT_W-1:0] cnt_q;
    logic             wrap;
    logic             ctl_en;

    pulse_accum_pin #(.SYNC_STAGES(SYNC_STAGES)) i_pin (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .level  (level),
        .rise   (rise),
        .fall   (fall)
    );

    pulse_accum_rate #(.DIV_A_LOG2(DIV_A_LOG2), .DIV_B_LOG2(DIV_B_LOG2)) i_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ctrl_q.en),
        .sel      (ctrl_q.rate),
        .ext_tick (presc_tick),
        .tick     (rate_tick)
    );

    pulse_accum_core #(.CNT_W(CNT_W)) i_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .load     (wr_count),
        .load_val (wr_data[CNT_W-1:0]),
        .cnt_q    (cnt_q),
        .wrap     (wrap)
    );

    // Decode register writes.
    always_comb begin
        wr_ctrl  = wr_en && (addr == ADDR_CTRL);
        wr_flag  = wr_en && (addr == ADDR_FLAG);
        wr_count = wr_en && (addr == ADDR_COUNT);
        ctl_en   = ctrl_q.en;
    end

    // Mode logic: choose the counted edge, the gate level and the step.
    always_comb begin
        edge_hit = ctrl_q.pol ? rise : fall;
        gate_on  = ctrl_q.pol ? ~level : level;
        step     = ctrl_q.en & (ctrl_q.gated ? (gate_on & rate_tick) : edge_hit);
        edge_set = ctrl_q.en & edge_hit;
    end

    // Control register: seven stored bits, the top bit is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    // Flags: hardware set beats a write-one clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_flag_q <= 1'b0;
            ovf_flag_q  <= 1'b0;
        end else begin
            edge_flag_q <= edge_set | (edge_flag_q & ~(wr_flag & wr_data[FLAG_EDGE_BIT]));
            ovf_flag_q  <= wrap     | (ovf_flag_q  & ~(wr_flag & wr_data[FLAG_OVF_BIT]));
        end
    end

    // Read multiplexer, zero-extended to the data width.
    always_comb begin
        rd_data = '0;
        unique case (addr)
            ADDR_CTRL:  rd_data[CTRL_W-1:0]   = ctrl_q;
            ADDR_FLAG:  begin
                rd_data[FLAG_EDGE_BIT] = edge_flag_q;
                rd_data[FLAG_OVF_BIT]  = ovf_flag_q;
            end
            ADDR_COUNT: rd_data[CNT_W-1:0]    = cnt_q;
            default:    rd_data = '0;
        endcase
    end

    // Interrupt outputs gated by their enables.
    always_comb begin
        irq_edge = ctrl_q.edge_ie & edge_flag_q;
        irq_ovf  = ctrl_q.ovf_ie  & ovf_flag_q;
    end
endmodule

// File: rtl/pulse_accum_checker.sv
// Checker for pulse_accum: temporal properties over the register port and
// the state of the counter and flags. Attached by bind below.
module pulse_accum_checker
    import pulse_accum_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] load_val,
    input  logic             clr_edge,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic             edge_flag_q,
    input  logic             ovf_flag_q,
    input  logic             step,
    input  logic             edge_set,
    input  logic             ctl_en
);
    logic cnt_wr;
    assign cnt_wr = wr_en && (addr == ADDR_COUNT);

    assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_en && !cnt_wr) |=> $stable(cnt_q));

    assert_no_flag_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> !$rose(edge_flag_q));

    assert_wrap_sets_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((&cnt_q) && step && !cnt_wr) |=> (cnt_q == '0 && ovf_flag_q));

    assert_clear_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_FLAG && clr_edge && !edge_set) |=> !edge_flag_q);

    assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_q == $past(load_val)));

    assert_single_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
endmodule

bind pulse_accum pulse_accum_checker #(.CNT_W(CNT_W)) i_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .addr        (addr),
    .load_val    (wr_data[CNT_W-1:0]),
    .clr_edge    (wr_data[0]),
    .cnt_q       (cnt_q),
    .edge_flag_q (edge_flag_q),
    .ovf_flag_q  (ovf_flag_q),
    .step        (step),
    .edge_set    (edge_set),
    .ctl_en      (ctl_en)
);

// File: tb/test_pulse_accum.sv
// Bench for pulse_accum: sweeps edge counts and gate widths for both
// polarities, each rate source, wrap, flag clearing, interrupts and
// load priority. Small dividers keep the sweeps short.
module test_pulse_accum;
    localparam int DW = 16;
    localparam int CW = 16;
    localparam int DA = 2;
    localparam int DB = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    addr = 2'd0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          pin_in = 1'b0;
    logic          presc_tick = 1'b0;
    logic          irq_edge, irq_ovf;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    pulse_accum #(.DATA_W(DW), .CNT_W(CW), .SYNC_STAGES(2),
                  .DIV_A_LOG2(DA), .DIV_B_LOG2(DB)) i_pulse_accum (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
        .presc_tick(presc_tick), .irq_edge(irq_edge), .irq_ovf(irq_ovf)
    );

    // Control word builder: en bit6, gated bit5, pol bit4, rate 3:2, ovf_ie 1, edge_ie 0.
    function automatic logic [DW-1:0] cw(input int en, input int g, input int p,
                                         input int r, input int oi, input int ei);
        return DW'((en << 6) | (g << 5) | (p << 4) | (r << 2) | (oi << 1) | ei);
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [DW-1:0] v);
        addr = a;
        #1 v = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl", v, 0);
        rd(2'd1, v); chk("R1 flags", v, 0);
        rd(2'd2, v); chk("R1 count", v, 0);
        chk("R1 irq_edge", irq_edge, 0);
        chk("R1 irq_ovf", irq_ovf, 0);

        // R11 control layout, top bit not stored
        wr(2'd0, 16'h00FF);
        rd(2'd0, v); chk("R11 ctrl readback", v, 16'h007F);
        wr(2'd0, 16'h0000);

        // R3 R5 R12 event sweep over polarity and pulse count
        for (int p = 0; p < 2; p++) begin
            for (int n = 0; n < 7; n++) begin
                pin_in = 1'b0; idle(4);
                wr(2'd2, 0); wr(2'd1, 3);
                wr(2'd0, cw(1, 0, p, 0, 0, 0));
                for (int k = 0; k < n; k++) begin
                    pin_in = 1'b1; idle(2);
                    pin_in = 1'b0; idle(2);
                end
                pin_in = 1'b1; idle(5);
                rd(2'd2, v); chk("R3 R12 event count", v, n + p);
                rd(2'd1, v); chk("R5 event edge flag", v, (n + p) > 0 ? 1 : 0);
                wr(2'd0, 0);
                pin_in = 1'b0; idle(4);
            end
        end

        // R2 disabled: pulses leave count and flags alone, load still works
        wr(2'd1, 3); wr(2'd2, 7);
        wr(2'd0, cw(0, 0, 0, 0, 1, 1));
        for (int k = 0; k < 3; k++) begin
            pin_in = 1'b1; idle(2); pin_in = 1'b0; idle(2);
        end
        idle(4);
        rd(2'd2, v); chk("R2 count held", v, 7);
        rd(2'd1, v); chk("R2 no flag", v, 0);

        // R4 R5 gated width sweep, every-clock rate, both polarities
        for (int p = 0; p < 2; p++) begin
            for (int n = 1; n <= 10; n++) begin
                wr(2'd0, 0);
                pin_in = (p == 1); idle(4);
                wr(2'd2, 0); wr(2'd1, 3);
                wr(2'd0, cw(1, 1, p, 1, 0, 0));
                idle(3);
                pin_in = (p == 0);
                idle(n);
                if (n == 10) begin
                    rd(2'd1, v); chk("R5 leading edge no flag", v, 0);
                end
                pin_in = (p == 1);
                idle(6);
                rd(2'd2, v); chk("R4 gated width", v, n);
                rd(2'd1, v); chk("R5 trailing edge flag", v, 1);
            end
        end
        wr(2'd0, 0);

        // R6 R4 external strobe: counts only at active level
        pin_in = 1'b1; idle(4);
        wr(2'd2, 0); wr(2'd1, 3);
        wr(2'd0, cw(1, 1, 0, 0, 0, 0));
        for (int k = 0; k < 5; k++) begin
            presc_tick = 1'b1; idle(1); presc_tick = 1'b0; idle(2);
        end
        idle(3);
        rd(2'd2, v); chk("R6 external strobe", v, 5);
        pin_in = 1'b0; idle(5);
        for (int k = 0; k < 4; k++) begin
            presc_tick = 1'b1; idle(1); presc_tick = 1'b0; idle(2);
        end
        idle(3);
        rd(2'd2, v); chk("R4 inactive level ignores ticks", v, 5);
        wr(2'd0, 0);

        // R6 divided rates, windows centred between ticks
        pin_in = 1'b1; idle(4);
        for (int r = 2; r < 4; r++) begin
            for (int kk = 1; kk <= 3; kk++) begin
                int div;
                div = (r == 2) ? (1 << DA) : (1 << DB);
                wr(2'd2, 0);
                wr(2'd0, cw(1, 1, 0, r, 0, 0));
                idle(kk * div + div / 2 - 1);
                wr(2'd0, 0);
                idle(2);
                rd(2'd2, v); chk("R6 divided rate", v, kk);
            end
        end
        pin_in = 1'b0; idle(4);

        // R7 R9 R8 wrap, overflow interrupt and flag clearing
        wr(2'd1, 3);
        wr(2'd2, 16'hFFFD);
        wr(2'd0, cw(1, 1, 0, 1, 1, 0));
        pin_in = 1'b1; idle(5); pin_in = 1'b0; idle(6);
        rd(2'd2, v); chk("R7 wrapped count", v, 2);
        rd(2'd1, v); chk("R7 overflow flag", v, 3);
        chk("R9 irq_ovf high", irq_ovf, 1);
        chk("R9 irq_edge masked", irq_edge, 0);
        wr(2'd1, 0);
        rd(2'd1, v); chk("R8 zero write no effect", v, 3);
        wr(2'd1, 1);
        rd(2'd1, v); chk("R8 clear edge only", v, 2);
        chk("R9 irq_ovf still high", irq_ovf, 1);
        wr(2'd1, 2);
        rd(2'd1, v); chk("R8 clear overflow", v, 0);
        chk("R9 irq_ovf low", irq_ovf, 0);

        // R9 edge interrupt in event mode, rising edge
        wr(2'd0, cw(1, 0, 1, 0, 0, 1));
        idle(2);
        chk("R9 irq_edge idle", irq_edge, 0);
        pin_in = 1'b1; idle(5);
        chk("R9 irq_edge set", irq_edge, 1);
        wr(2'd1, 1);
        idle(1);
        chk("R9 irq_edge cleared", irq_edge, 0);
        wr(2'd0, 0);
        pin_in = 1'b0; idle(4);

        // R10 load beats a same-cycle increment
        pin_in = 1'b1; idle(4);
        wr(2'd0, cw(1, 1, 0, 1, 0, 0));
        idle(3);
        wr(2'd2, 16'h0100);
        rd(2'd2, v); chk("R10 load wins", v, 16'h0100);
        idle(4);
        rd(2'd2, v); chk("R10 counting resumes", v, 16'h0104);
        wr(2'd0, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule